// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns bytes from a CPU-side write port into asynchronous serial frames on a single output line. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts sixteen pulses of a transmit-clock enable. Bytes pass through a one-byte holding buffer into a shift register. A byte moves from the buffer to the shifter only when three things are true: the shifter is free, the transmit-enable command input is high, and the modem clear-to-send input is high.

The write port is a valid/ready handshake. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while the holding buffer is empty and `tx_en` is set. A writer that sees `s_ready` low keeps `s_valid` and `s_data` steady until ready returns. Clear-to-send does not hold the port back, so software can preload a byte during a flow-control pause.

The status flags are exact at all times, including while transmission is halted. The transmit interrupt request follows the ready flag and is masked when `tx_en` is cleared. That lets a shared interrupt line carry a receive-ready source on its own. The transmitter never re-sends a byte. After any pause it sends only a byte that was newly written.

Top module: `usart_tx_cts`

## Requirements
- R1: The line idles at 1. Each frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit holds for exactly 16 `tick16` pulses.
- R2: When the shifter is free, the buffer holds a byte, and `tx_en` and `cts` are both 1, the start bit begins on the first `tick16` edge. `txd` reads 0 right after that edge, with no extra bit-time delay, even for the first frame after reset.
- R3: If `cts` drops while a frame is on the line, that frame completes unchanged. No new frame starts while `cts` or `tx_en` is 0, even if the buffer holds a byte.
- R4: Each written byte is sent exactly once. Toggling `cts` or `tx_en` with the buffer empty never starts a frame.
- R5: `s_ready` and `tx_rdy` equal (buffer empty AND `tx_en`). `cts` has no effect on them.
- R6: A write is taken only on an edge where `s_valid` and `s_ready` are both 1. `tx_rdy` and `tx_empty` read 0 right after that same edge.
- R7: `tx_empty` is 1 exactly when the buffer is empty and no frame is on the line. It stays true and steady while `tx_en` or `cts` is 0. In `status`, bit 0 is `tx_rdy`, bit 2 is `tx_empty`, and the other bits are 0.
- R8: `tx_irq` equals `tx_rdy`, so it is 0 whenever `tx_en` is 0.
- R9: If the next byte is already buffered when a stop bit ends, and `cts` and `tx_en` are 1, the next start bit begins on the edge that ends the stop bit, with no idle gap.
- R10: After reset, `txd` is 1, the buffer and shifter are empty, and `status` reads 0x04 while `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit-enable command bit |
| cts | input | 1 | Clear to send, active high |
| tick16 | input | 1 | Transmit-clock enable, 16 pulses per bit |
| s_valid | input | 1 | Write data valid |
| s_data | input | 8 | Byte to transmit |
| s_ready | output | 1 | Holding buffer can accept a byte |
| txd | output | 1 | Serial data line |
| tx_rdy | output | 1 | Buffer empty and transmitter enabled |
| tx_empty | output | 1 | Buffer and shifter both idle |
| tx_irq | output | 1 | Transmit interrupt request |
| status | output | 8 | Status byte (bit 0 ready, bit 2 empty) |

## Verification
The two functions that can fall in the same cycle are a CPU write being accepted and the shifter finishing a stop bit. The bench lines them up by counting tick pulses from the middle of a stop bit. It raises `s_valid` so the write lands on the exact edge that ends the frame. The check is that `tx_empty` does not pulse high, that `txd` stays high for that edge (the buffer was still empty when the edge arrived), and that the new byte's start bit appears on the following tick. A second line-up pairs a buffered byte with the end of a stop bit, and the bench expects the start bit on that same edge.

// File: rtl/txu_pkg.sv
package txu_pkg;
  typedef enum logic {SH_IDLE = 1'b0, SH_BUSY = 1'b1} sh_state_e;
  localparam int STAT_W           = 8;
  localparam int STAT_TXRDY_BIT   = 0;
  localparam int STAT_TXEMPTY_BIT = 2;
endpackage

// File: rtl/txu_hold_buf.sv
module txu_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

  // R4
  no_take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  // R4
  take_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !full);
  // R6
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/txu_shifter.sv
module txu_shifter
  import txu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go_ok,
  input  logic [DATA_W-1:0] data_in,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int SUB_W   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  sh_state_e          st;
  logic [FRAME_W-1:0] sh;
  logic [SUB_W-1:0]   sub;
  logic [BIT_W-1:0]   bitc;
  logic               bit_end;
  logic               finish;
  logic               free;

  assign busy    = (st == SH_BUSY);
  assign bit_end = busy && tick && (sub == SUB_LAST);
  assign finish  = bit_end && (bitc == BIT_LAST);
  assign free    = !busy || finish;
  assign take    = tick && free && go_ok;
  assign txd     = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      sh   <= '1;
      sub  <= '0;
      bitc <= '0;
    end else if (take) begin
      st   <= SH_BUSY;
      sh   <= {1'b1, data_in, 1'b0};
      sub  <= '0;
      bitc <= '0;
    end else if (finish) begin
      st   <= SH_IDLE;
      sh   <= '1;
      sub  <= '0;
      bitc <= '0;
    end else if (bit_end) begin
      sub  <= '0;
      bitc <= bitc + BIT_W'(1);
      sh   <= {1'b1, sh[FRAME_W-1:1]};
    end else if (busy && tick) begin
      sub  <= sub + SUB_W'(1);
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R1
  txd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && busy));
  // R3
  frame_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);
endmodule

// File: rtl/txu_flags.sv
module txu_flags
  import txu_pkg::*;
(
  input  logic              hold_full,
  input  logic              busy,
  input  logic              tx_en,
  output logic              tx_rdy,
  output logic              tx_empty,
  output logic              tx_irq,
  output logic [STAT_W-1:0] status
);
  assign tx_rdy   = !hold_full && tx_en;
  assign tx_empty = !hold_full && !busy;
  assign tx_irq   = tx_rdy;

  always_comb begin
    status                   = '0;
    status[STAT_TXRDY_BIT]   = tx_rdy;
    status[STAT_TXEMPTY_BIT] = tx_empty;
  end
endmodule

// File: rtl/usart_tx_cts.sv
module usart_tx_cts
  import txu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cts,
  input  logic              tick16,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_empty,
  output logic              tx_irq,
  output logic [STAT_W-1:0] status
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              wr_en;
  logic              go_ok;

  assign s_ready = tx_rdy;
  assign wr_en   = s_valid && s_ready;
  assign go_ok   = hold_full && tx_en && cts;

  txu_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (s_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  txu_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .go_ok   (go_ok),
    .data_in (hold_data),
    .take    (take),
    .busy    (busy),
    .txd     (txd)
  );

  txu_flags u_flags (
    .hold_full (hold_full),
    .busy      (busy),
    .tx_en     (tx_en),
    .tx_rdy    (tx_rdy),
    .tx_empty  (tx_empty),
    .tx_irq    (tx_irq),
    .status    (status)
  );

  // R3
  no_start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || !cts) |-> !take);
  // R5
  rdy_ignores_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !hold_full) |-> s_ready);
  // R6
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (!tx_empty && !tx_rdy));
  // R7
  empty_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> $stable(tx_empty));
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq);
endmodule

// File: tb/tb_usart_tx_cts.sv
`timescale 1ns/1ps
module tb_usart_tx_cts;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       cts = 1'b1;
  logic       tick16;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_ready, txd, tx_rdy, tx_empty, tx_irq;
  logic [7:0] status;
  logic [1:0] tdiv;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick16 = (tdiv == 2'd3);

  usart_tx_cts dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts(cts), .tick16(tick16),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .txd(txd),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty), .tx_irq(tx_irq), .status(status)
  );

  // {data, line order of data bits with first bit in the MSB}
  localparam logic [15:0] VEC [8] = '{
    {8'h55, 8'hAA}, {8'hA3, 8'hC5}, {8'h00, 8'h00}, {8'hFF, 8'hFF},
    {8'h81, 8'h81}, {8'h3C, 8'h3C}, {8'h0F, 8'hF0}, {8'h12, 8'h48}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] seq, output logic ok);
    int n = 0;
    ok  = 1'b1;
    seq = 8'h00;
    @(negedge clk);
    while (txd !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) ok = 1'b0;
    wait_ticks(8);
    if (txd !== 1'b0) ok = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wait_ticks(16);
      seq = {seq[6:0], txd};
    end
    wait_ticks(16);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic count_low(input int cyc, output int lows);
    lows = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] seq;
    logic ok;
    int lows;
    int bad;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 txd", txd, 1);
    check("R10 status", status, 8'h04);
    check("R8 irq masked", tx_irq, 0);
    check("R5 ready needs en", s_ready, 0);

    tx_en = 1'b1;
    #1;
    check("R5 ready", s_ready, 1);
    check("R7 status en", status, 8'h05);
    check("R8 irq", tx_irq, 1);

    // first frame after reset: flags drop at accept edge, start on first tick
    send(8'h5A);
    check("R6 status after write", status, 8'h00);
    check("R6 ready after write", s_ready, 0);
    check("R2 still idle", txd, 1);
    fork
      recv(seq, ok);
      begin
        wait_ticks(1);
        @(negedge clk);
        check("R2 start on first tick", txd, 0);
        check("R7 true state while sending", status, 8'h01);
      end
    join
    check("R1 frame 5A", ok, 1);
    check("R1 data 5A", seq, 8'h5A);

    // table of frames
    for (int i = 0; i < 8; i++) begin
      fork
        send(VEC[i][15:8]);
        recv(seq, ok);
      join
      check("R1 table frame", ok, 1);
      check("R1 table data", seq, VEC[i][7:0]);
    end
    wait_ticks(20);

    // CTS drop mid-frame, preload during pause
    fork
      recv(seq, ok);
      begin
        send(8'hC3);
        wait_ticks(40);
        cts = 1'b0;
        #1;
        check("R5 ready while cts low", s_ready, 1);
        send(8'h96);
      end
    join
    check("R3 frame completes", ok, 1);
    check("R3 data C3", seq, 8'hC3);
    count_low(300, lows);
    check("R3 no start while cts low", lows, 0);
    check("R7 empty false held", tx_empty, 0);
    check("R7 status held", status, 8'h00);
    cts = 1'b1;
    recv(seq, ok);
    check("R3 resumed frame", ok, 1);
    check("R3 data 96", seq, 8'h69);

    // no re-send after stop
    wait_ticks(20);
    check("R7 empty idle", tx_empty, 1);
    @(negedge clk); tx_en = 1'b0;
    repeat (10) @(negedge clk); cts = 1'b0;
    repeat (10) @(negedge clk); tx_en = 1'b1;
    repeat (10) @(negedge clk); cts = 1'b1;
    count_low(300, lows);
    check("R4 no repeat", lows, 0);
    check("R4 still empty", tx_empty, 1);

    // halted transmitter: empty stays valid and steady
    tx_en = 1'b0;
    bad = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (tx_empty !== 1'b1) bad++;
    end
    check("R7 empty steady disabled", bad, 0);
    check("R7 status disabled", status, 8'h04);
    check("R8 irq off", tx_irq, 0);
    tx_en = 1'b1;
    cts = 1'b0;
    send(8'hE7);
    tx_en = 1'b0;
    cts = 1'b1;
    bad = 0;
    lows = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (tx_empty !== 1'b0) bad++;
      if (txd !== 1'b1) lows++;
    end
    check("R7 not empty steady", bad, 0);
    check("R3 en low blocks start", lows, 0);
    check("R8 irq off with byte", tx_irq, 0);
    tx_en = 1'b1;
    recv(seq, ok);
    check("R3 frame after en", ok, 1);
    check("R3 data E7", seq, 8'hE7);

    // back-to-back frames
    wait_ticks(10);
    send(8'h11);
    fork
      recv(seq, ok);
      send(8'h22);
    join
    check("R9 first frame", ok, 1);
    check("R9 data 11", seq, 8'h88);
    wait_ticks(8);
    @(negedge clk);
    check("R9 no gap", txd, 0);
    recv(seq, ok);
    check("R9 second frame", ok, 1);
    check("R9 data 22", seq, 8'h44);

    // write accepted on the edge that ends the stop bit
    wait_ticks(7);
    @(negedge clk);
    while (!tick16) @(negedge clk);
    check("R5 ready at stop end", s_ready, 1);
    s_valid = 1'b1;
    s_data  = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check("R6 line high at coincident edge", txd, 1);
    check("R6 empty no pulse", tx_empty, 0);
    check("R6 status coincident", status, 8'h00);
    fork
      recv(seq, ok);
      begin
        wait_ticks(1);
        @(negedge clk);
        check("R2 start next tick", txd, 0);
      end
    join
    check("R1 coincident frame", ok, 1);
    check("R1 data 3C", seq, 8'h3C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule